// File: doc/BRIEF.md
# Asynchronous Serial Transceiver With Programmable Character Format

This block is the asynchronous side of a programmable serial port for a processor bus. A single select input picks between the control/status space and the data space. After reset, or after an internal-reset command, the first control write is taken as the format word. Every later control write is taken as a command word. The format word sets the character length, the parity and the stop-bit length. It also sets the oversampling factor, which is 16 or 64 ticks of the serial clock enable per bit.

The transmitter has a one-character holding register and a shift register. The receiver detects a start edge and confirms it at mid-bit. It then samples every later bit at its centre. Reading the data space returns the last received character and clears the receive-ready flag. Writing the data space loads a character and clears the transmit-ready flag. A status byte reports the ready flags, the empty flag, the three sticky error flags and the level of the peer-ready input.

Top module: `usart_async`

## Requirements
- R1: After reset the status byte reads 0x85 when `modem_dsr` is high, `ser_out` is high, and `modem_dtr` and `modem_rts` are low.
- R2: The first control write after reset, or after a command with bit 6 set, loads the format word. Later control writes load the command word. A command with bit 6 set clears the command word and re-arms the format pointer.
- R3: Status bits are: 0 transmit ready, 1 receive ready, 2 transmitter empty, 3 parity error, 4 overrun, 5 framing error, 6 always 0, 7 the level of `modem_dsr`.
- R4: A transmitted frame is a low start bit, then 5+fmt[3:2] data bits LSB first, then a parity bit when fmt[4]=1, then a high stop. The parity bit makes the number of ones even when fmt[5]=1 and odd when fmt[5]=0.
- R5: Each start, data and parity bit lasts F pulses of `baud_tick`, where F is 64 when fmt[1:0]=11 and 16 otherwise.
- R6: The stop time is 1.5F ticks when fmt[7:6]=10, 2F ticks when fmt[7:6]=11, and F ticks otherwise. Transmitter empty rises on the last stop tick.
- R7: A data write clears transmit ready. The character waits in the holding register while command bit 0 (transmit enable) is 0, and moves into the shifter once that bit is 1. Transmitter empty implies transmit ready.
- R8: A received character sets receive ready and is returned right-aligned with the unused upper bits at 0. A data-space read clears receive ready.
- R9: With fmt[4]=1, a received parity bit that does not match the fmt[5] sense sets the parity error flag.
- R10: A first stop bit sampled low sets the framing error flag. The character is still delivered.
- R11: A character that completes while receive ready is still 1 sets the overrun flag and replaces the held character.
- R12: A command with bit 4 set clears the parity, overrun and framing flags.
- R13: Command bit 3 forces `ser_out` low. When it is clear and the transmitter is empty, `ser_out` is high.
- R14: With command bit 2 at 0, incoming frames are ignored. `modem_dtr` follows command bit 1 and `modem_rts` follows command bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Serial clock enable, one clk cycle per tick |
| bus_ctl_sel | input | 1 | 1 selects format/command/status, 0 selects data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (status or received character) |
| ser_out | output | 1 | Serial transmit line |
| ser_in | input | 1 | Serial receive line (asynchronous) |
| modem_dsr | input | 1 | Peer-ready level shown in status bit 7 |
| modem_dtr | output | 1 | Terminal-ready output |
| modem_rts | output | 1 | Request-to-send output |

## Verification
The assertions take for granted that `bus_wr` and `bus_rd` are single-cycle strobes that never occur together. They also assume that `baud_tick` is a one-cycle pulse, and that `ser_in` changes no faster than once per bit time once a frame has started. The stimulus follows these rules. Each bus access is a one-cycle strobe driven on the falling clock edge, and ticks come every fourth clock. Received frames hold each level for exactly F ticks. A low stop bit is released shortly after its centre, so that the receiver's false-start check sees the line high again.

// File: rtl/usart_pkg.sv
// Shared types for the asynchronous serial transceiver.
// Assumes the format word layout used by the control block and the datapaths.
package usart_pkg;
    typedef struct packed {
        logic [1:0] stop;    // stop length code
        logic       even;    // parity sense
        logic       par_en;  // parity present
        logic [1:0] len;     // character length code
        logic [1:0] baud;    // oversampling code
    } fmt_t;

    // Number of data bits for a length code.
    function automatic logic [3:0] char_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction
endpackage

// File: rtl/usart_ctrl.sv
// Control-space write decoder: format word versus command word.
// Assumes one-cycle write strobes; the command byte is only sampled, and error reset is a pulse.
module usart_ctrl
    import usart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] wdata,
    output fmt_t       fmt,
    output logic       tx_en,
    output logic       dtr,
    output logic       rx_en,
    output logic       brk,
    output logic       rts,
    output logic       err_clr
);
    logic want_fmt;

    // Error reset pulse for a command write with bit 4 set.
    assign err_clr = ctl_wr & ~want_fmt & ~wdata[6] & wdata[4];

    // Format pointer, format word and stored command bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_fmt <= 1'b1;
            fmt      <= '0;
            {tx_en, dtr, rx_en, brk, rts} <= '0;
        end else if (ctl_wr) begin
            if (want_fmt) begin
                fmt      <= fmt_t'(wdata);
                want_fmt <= 1'b0;
            end else if (wdata[6]) begin
                want_fmt <= 1'b1;
                {tx_en, dtr, rx_en, brk, rts} <= '0;
            end else begin
                tx_en <= wdata[0];
                dtr   <= wdata[1];
                rx_en <= wdata[2];
                brk   <= wdata[3];
                rts   <= wdata[5];
            end
        end
    end
endmodule

// File: rtl/usart_tx.sv
// Transmitter: one holding register and a frame shifter timed by serial ticks.
// Assumes tick is a one-cycle pulse; a frame once started runs to its end.
module usart_tx
    import usart_pkg::*;
#(
    parameter int FAST = 16,
    parameter int SLOW = 64,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  fmt_t          fmt,
    input  logic          tx_en,
    input  logic          brk,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          ser_out,
    output logic          tx_rdy,
    output logic          tx_empty
);
    localparam int CW = $clog2(2 * SLOW + 1);
    localparam int FW = DW + 3;

    logic [DW-1:0] hold, word;
    logic          full, busy, load;
    logic [FW-1:0] sh, frame;
    logic [3:0]    slot, last, nbits;
    logic [CW-1:0] cnt, unit, stop_len, cur_len;

    // Frame layout and bit lengths from the format word.
    always_comb begin
        unit  = (fmt.baud == 2'b11) ? CW'(SLOW) : CW'(FAST);
        case (fmt.stop)
            2'b10:   stop_len = unit + (unit >> 1);
            2'b11:   stop_len = unit << 1;
            default: stop_len = unit;
        endcase
        nbits = char_bits(fmt.len);
        last  = nbits + {3'b000, fmt.par_en} + 4'd1;
        for (int i = 0; i < DW; i++) word[i] = (i < int'(nbits)) ? hold[i] : 1'b0;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DW; i++) if (i < int'(nbits)) frame[i+1] = hold[i];
        if (fmt.par_en) frame[nbits+4'd1] = (^word) ^ ~fmt.even;
        cur_len = (slot == last) ? stop_len : unit;
    end

    assign load = full & ~busy & tx_en;

    // Holding register: a bus write wins over a move into the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
        end else if (wr) begin
            hold <= wdata;
            full <= 1'b1;
        end else if (load) begin
            full <= 1'b0;
        end
    end

    // Shifter and per-bit tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            busy <= 1'b0;
            slot <= '0;
            cnt  <= '0;
        end else if (load) begin
            sh   <= frame;
            busy <= 1'b1;
            slot <= '0;
            cnt  <= '0;
        end else if (busy && tick) begin
            if (cnt == cur_len - 1'b1) begin
                cnt <= '0;
                if (slot == last) begin
                    busy <= 1'b0;
                end else begin
                    slot <= slot + 4'd1;
                    sh   <= {1'b1, sh[FW-1:1]};
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign ser_out  = brk ? 1'b0 : (busy ? sh[0] : 1'b1);
    assign tx_rdy   = ~full;
    assign tx_empty = ~busy & ~full;
endmodule

// File: rtl/usart_rx.sv
// Receiver: start-edge detect, mid-bit confirm, centre sampling, sticky error flags.
// Assumes rxd is already synchronised to clk and tick is a one-cycle pulse.
module usart_rx
    import usart_pkg::*;
#(
    parameter int FAST = 16,
    parameter int SLOW = 64,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          slow,
    input  logic [1:0]    len,
    input  logic          par_en,
    input  logic          even,
    input  logic          rx_en,
    input  logic          rxd,
    input  logic          rd_ack,
    input  logic          err_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_rdy,
    output logic          pe,
    output logic          oe,
    output logic          fe,
    output logic          done
);
    localparam int CW = $clog2(SLOW + 1);
    typedef enum logic [1:0] {R_IDLE, R_START, R_BITS, R_STOP} rx_state_e;

    rx_state_e     st;
    logic [CW-1:0] cnt, bit_len, half_len;
    logic [3:0]    idx, nbits, slots;
    logic [DW:0]   rbuf;
    logic [DW-1:0] word;
    logic          par_bad, bit_end;

    // Bit timing, data extraction and parity check.
    always_comb begin
        bit_len  = slow ? CW'(SLOW) : CW'(FAST);
        half_len = bit_len >> 1;
        nbits    = char_bits(len);
        slots    = nbits + {3'b000, par_en};
        for (int i = 0; i < DW; i++) word[i] = (i < int'(nbits)) ? rbuf[i] : 1'b0;
        par_bad  = par_en & ((^word) ^ rbuf[nbits] ^ ~even);
        bit_end  = (cnt == bit_len - 1'b1);
    end

    assign done = rx_en & tick & (st == R_STOP) & bit_end;

    // Frame state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= R_IDLE;
            cnt  <= '0;
            idx  <= '0;
            rbuf <= '0;
        end else if (!rx_en) begin
            st <= R_IDLE;
        end else if (tick) begin
            case (st)
                R_IDLE: if (!rxd) begin
                    st  <= R_START;
                    cnt <= '0;
                end
                R_START: if (cnt == half_len - 1'b1) begin
                    cnt <= '0;
                    if (!rxd) begin
                        st   <= R_BITS;
                        idx  <= '0;
                        rbuf <= '0;
                    end else begin
                        st <= R_IDLE;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
                R_BITS: if (bit_end) begin
                    cnt       <= '0;
                    rbuf[idx] <= rxd;
                    idx       <= idx + 4'd1;
                    if (idx == slots - 4'd1) st <= R_STOP;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (bit_end) begin
                    st  <= R_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Delivered character, ready flag and sticky errors; a completion wins over read and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_rdy  <= 1'b0;
            {pe, oe, fe} <= '0;
        end else if (done) begin
            rx_data <= word;
            rx_rdy  <= 1'b1;
            oe      <= oe | (rx_rdy & ~rd_ack);
            pe      <= pe | par_bad;
            fe      <= fe | ~rxd;
        end else begin
            if (rd_ack) rx_rdy <= 1'b0;
            if (err_clr) {pe, oe, fe} <= '0;
        end
    end
endmodule

// File: rtl/usart_async.sv
// Top level: bus decode, status byte, input synchroniser, transmitter and receiver.
// Assumes single-cycle bus strobes; read data is combinational on the select input.
module usart_async
    import usart_pkg::*;
#(
    parameter int FAST = 16,
    parameter int SLOW = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       bus_ctl_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       ser_out,
    input  logic       ser_in,
    input  logic       modem_dsr,
    output logic       modem_dtr,
    output logic       modem_rts
);
    fmt_t       fmt;
    logic       tx_en, rx_en, brk_on, err_clr;
    logic       tx_rdy, tx_empty, rx_rdy, pe, oe, fe, rx_done;
    logic [7:0] rx_data, status;
    logic [1:0] in_sync;

    // Two-stage synchroniser for the serial input, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) in_sync <= 2'b11;
        else        in_sync <= {in_sync[0], ser_in};
    end

    usart_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(bus_wr & bus_ctl_sel), .wdata(bus_wdata),
        .fmt(fmt), .tx_en(tx_en), .dtr(modem_dtr), .rx_en(rx_en), .brk(brk_on),
        .rts(modem_rts), .err_clr(err_clr)
    );

    usart_tx #(.FAST(FAST), .SLOW(SLOW), .DW(8)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .fmt(fmt), .tx_en(tx_en),
        .brk(brk_on), .wr(bus_wr & ~bus_ctl_sel), .wdata(bus_wdata),
        .ser_out(ser_out), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
    );

    usart_rx #(.FAST(FAST), .SLOW(SLOW), .DW(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .slow(fmt.baud == 2'b11),
        .len(fmt.len), .par_en(fmt.par_en), .even(fmt.even), .rx_en(rx_en),
        .rxd(in_sync[1]), .rd_ack(bus_rd & ~bus_ctl_sel), .err_clr(err_clr),
        .rx_data(rx_data), .rx_rdy(rx_rdy), .pe(pe), .oe(oe), .fe(fe), .done(rx_done)
    );

    assign status    = {modem_dsr, 1'b0, fe, oe, pe, tx_empty, rx_rdy, tx_rdy};
    assign bus_rdata = bus_ctl_sel ? status : rx_data;
endmodule

// File: rtl/usart_async_chk.sv
// Property checker bound to the top level.
// Assumes single-cycle strobes on the bus inputs.
module usart_async_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ctl_sel,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       ser_out,
    input logic [7:0] status,
    input logic       brk_on,
    input logic       rx_done,
    input logic       err_clr
);
    AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n) brk_on |-> !ser_out); // R13
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (status[2] && !brk_on) |-> ser_out); // R13
    AST_WRITE_CLEARS_TXRDY: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && !bus_ctl_sel) |=> !status[0]); // R7
    AST_EMPTY_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n) status[2] |-> status[0]); // R7
    AST_READ_CLEARS_RXRDY: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && !bus_ctl_sel && !rx_done) |=> !status[1]); // R8
    AST_DONE_SETS_RXRDY: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> status[1]); // R8
    AST_ERROR_RESET: assert property (@(posedge clk) disable iff (!rst_n) (err_clr && !rx_done) |=> (status[5:3] == 3'b000)); // R12
endmodule

bind usart_async usart_async_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_ctl_sel(bus_ctl_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .ser_out(ser_out), .status(status), .brk_on(brk_on), .rx_done(rx_done), .err_clr(err_clr)
);

// File: tb/usart_async_test.sv
// Bench: behavioural model of the control pointer and of frame timing, checked against the ports.
module usart_async_test;
    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic bus_ctl_sel = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, ser_in = 1'b1, modem_dsr = 1'b1;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic ser_out, modem_dtr, modem_rts;
    int total = 0, bad = 0, tdiv = 0;
    logic m_want_fmt = 1'b1;
    logic [7:0] m_cmd = 8'h00;
    logic [7:0] v;

    always #10 clk = ~clk;

    // Serial clock enable: one pulse every fourth clock.
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        baud_tick = (tdiv == 0);
    end

    usart_async uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_ctl_sel(bus_ctl_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_out(ser_out), .ser_in(ser_in), .modem_dsr(modem_dsr),
        .modem_dtr(modem_dtr), .modem_rts(modem_rts)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Per-clock comparison against the modelled command word.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R14 dtr follows command", modem_dtr, m_cmd[1]);
            check("R14 rts follows command", modem_rts, m_cmd[5]);
            if (m_cmd[3]) check("R13 break line low", ser_out, 1'b0);
        end
    end

    task automatic wait_ticks(input int n);
        int k = n;
        while (k > 0) begin
            @(posedge clk);
            if (baud_tick) k--;
        end
    endtask

    task automatic ctl_write(input logic [7:0] w);
        @(negedge clk);
        bus_ctl_sel = 1'b1; bus_wdata = w; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        if (m_want_fmt) m_want_fmt = 1'b0;
        else if (w[6]) begin m_cmd = 8'h00; m_want_fmt = 1'b1; end
        else m_cmd = w & 8'hAF;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic data_write(input logic [7:0] w);
        @(negedge clk);
        bus_ctl_sel = 1'b0; bus_wdata = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_ctl_sel = 1'b1;
        #1 check("R7 data write clears TxRDY", bus_rdata[0], 1'b0);
    endtask

    task automatic data_read(output logic [7:0] r);
        @(negedge clk);
        bus_ctl_sel = 1'b0; bus_rd = 1'b1;
        #1 r = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_ctl_sel = 1'b1;
    endtask

    // Expected frame built from the format fields, sampled at each bit centre.
    task automatic tx_frame(input string tag, input logic [7:0] d, input int n, input bit pen,
                            input bit even, input int stopc, input int f);
        bit q[$];
        bit par = 1'b0;
        int s = (stopc == 2) ? f + f / 2 : (stopc == 3) ? 2 * f : f;
        int guard = 0;
        q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin q.push_back(d[i]); par ^= d[i]; end
        if (pen) q.push_back(par ^ !even);
        q.push_back(1'b1);
        while (ser_out !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
        check({tag, " R4 start bit seen"}, ser_out, 1'b0);
        for (int k = 0; k < q.size(); k++) begin
            wait_ticks(k == 0 ? f / 2 : f);
            @(negedge clk);
            check($sformatf("%s R4 R5 bit %0d", tag, k), ser_out, q[k]);
        end
        wait_ticks(s - f / 2 - 1);
        @(negedge clk);
        check({tag, " R6 busy before last stop tick"}, bus_rdata[2], 1'b0);
        wait_ticks(1);
        @(negedge clk);
        check({tag, " R6 empty after last stop tick"}, bus_rdata[2], 1'b1);
        check({tag, " R13 idle line high"}, ser_out, 1'b1);
    endtask

    // Drive one frame on the receive line, each level held for f ticks.
    task automatic rx_frame(input logic [7:0] d, input int n, input bit pen, input bit pbit,
                            input bit stopb, input int f);
        @(negedge clk); ser_in = 1'b0; wait_ticks(f);
        for (int i = 0; i < n; i++) begin @(negedge clk); ser_in = d[i]; wait_ticks(f); end
        if (pen) begin @(negedge clk); ser_in = pbit; wait_ticks(f); end
        @(negedge clk); ser_in = stopb; wait_ticks(stopb ? f : f / 2 + 2);
        @(negedge clk); ser_in = 1'b1; wait_ticks(f);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R3 reset status", bus_rdata, 8'h85);
        check("R1 reset line high", ser_out, 1'b1);
        check("R1 reset dtr low", modem_dtr, 1'b0);

        ctl_write(8'h4E);                        // 8 bits, no parity, 1 stop, x16
        ctl_write(8'h26);                        // dtr, rx enable, rts; transmit off
        check("R2 second write is command", modem_dtr, 1'b1);
        data_write(8'hA5);
        wait_ticks(40);
        @(negedge clk);
        check("R7 held while transmit disabled", ser_out, 1'b1);
        check("R7 still not ready", bus_rdata[0], 1'b0);
        ctl_write(8'h27);
        tx_frame("8N1", 8'hA5, 8, 1'b0, 1'b0, 1, 16);

        ctl_write(8'h40);                        // internal reset
        check("R2 internal reset clears command", modem_dtr, 1'b0);
        ctl_write(8'hF2);                        // 5 bits, even parity, 2 stops, x16
        ctl_write(8'h27);
        data_write(8'h13);
        tx_frame("5E2", 8'h13, 5, 1'b1, 1'b1, 3, 16);

        ctl_write(8'h40);
        ctl_write(8'h9B);                        // 7 bits, odd parity, 1.5 stops, x64
        ctl_write(8'h27);
        data_write(8'h6C);
        tx_frame("7O1.5", 8'h6C, 7, 1'b1, 1'b0, 2, 64);

        ctl_write(8'h40);
        ctl_write(8'h4E);
        ctl_write(8'h27);
        rx_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1, 16);
        check("R8 receive ready set", bus_rdata[1], 1'b1);
        check("R8 no errors", bus_rdata[5:3], 3'b000);
        data_read(v);
        check("R8 received data", v, 8'h3C);
        @(negedge clk);
        check("R8 read clears receive ready", bus_rdata[1], 1'b0);

        rx_frame(8'h11, 8, 1'b0, 1'b0, 1'b1, 16);
        rx_frame(8'h22, 8, 1'b0, 1'b0, 1'b1, 16);
        check("R11 overrun flagged", bus_rdata[4], 1'b1);
        data_read(v);
        check("R11 newer character kept", v, 8'h22);
        ctl_write(8'h37);
        @(negedge clk);
        check("R12 error reset clears flags", bus_rdata[5:3], 3'b000);

        ctl_write(8'h2F);
        @(negedge clk);
        check("R13 break forces low", ser_out, 1'b0);
        ctl_write(8'h27);
        @(negedge clk);
        check("R13 break released", ser_out, 1'b1);

        modem_dsr = 1'b0;
        @(negedge clk);
        check("R3 status bit 7 follows dsr", bus_rdata, 8'h05);
        modem_dsr = 1'b1;

        ctl_write(8'h23);                        // receiver off
        rx_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1, 16);
        check("R14 frame ignored with receiver off", bus_rdata[1], 1'b0);
        data_read(v);
        check("R14 held data unchanged", v, 8'h22);

        ctl_write(8'h27);
        rx_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 16);
        check("R10 framing error", bus_rdata[5], 1'b1);
        check("R10 character delivered", bus_rdata[1], 1'b1);
        data_read(v);
        check("R10 data with low stop", v, 8'h81);
        ctl_write(8'h37);

        ctl_write(8'h40);
        ctl_write(8'h7A);                        // 7 bits, even parity, 1 stop, x16
        ctl_write(8'h27);
        rx_frame(8'h55, 7, 1'b1, 1'b1, 1'b1, 16);
        check("R9 parity error", bus_rdata[3], 1'b1);
        data_read(v);
        check("R9 data despite parity", v, 8'h55);
        ctl_write(8'h37);
        rx_frame(8'h2B, 7, 1'b1, 1'b0, 1'b1, 16);
        check("R9 correct parity accepted", bus_rdata[3], 1'b0);
        data_read(v);
        check("R9 good data", v, 8'h2B);

        ctl_write(8'h40);
        ctl_write(8'h42);                        // 5 bits, no parity, 1 stop, x16
        ctl_write(8'h27);
        rx_frame(8'hF5, 5, 1'b0, 1'b0, 1'b1, 16);
        data_read(v);
        check("R8 five-bit character right-aligned", v, 8'h15);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule